// File: doc/BRIEF.md
# Overlapping Register Window File

This block is the general-purpose register file of a RISC core, built around a ring of register windows. The core always names 32 logical registers. Eight of them are global and look the same from every procedure level. The other 24 are divided into three groups of eight: incoming parameters, locals and outgoing temporaries. The outgoing group of one window and the incoming group of the next window are the same physical registers. A call therefore moves arguments to the callee just by stepping the current window pointer forward. A return steps the pointer back.

The physical windows form a circular buffer. When a call would make the newest window overlap the oldest resident one, the block raises a one-cycle overflow trap. It then streams that oldest window's locals and incoming parameters out to memory as sixteen words through a valid/ready handshake, and only after that does it complete the call. When a return leaves the only resident window and the caller has been spilled, the block raises an underflow trap, reads the same sixteen words back in the same order, and then completes the return. While a transfer runs, the block holds `stall` high and ignores the core's write, call and return inputs. A return at nesting depth zero changes nothing and raises an error pulse.

Top module: `rwin_regfile`

## Requirements
- R1: After reset, the block is at nesting depth zero with the current and saved window pointers at 0. Every register reads as zero, `stall`, `mem_valid` and the three pulse outputs are low.
- R2: Logical register 0 always reads as zero, and a write to it has no effect.
- R3: Logical registers 1–7 are globals: a value written to one of them reads back unchanged at every nesting depth.
- R4: In each window, logical registers 8–15 are outgoing, 16–23 are local and 24–31 are incoming. After a call, the callee's incoming register 24+k reads the value the caller left in 8+k. After the matching return, the caller's registers read back unchanged.
- R5: When a write and a read address the same nonzero register in the same cycle, the read returns the value being written.
- R6: A write issued in the same cycle as an accepted call or return goes to the window that was active before the switch.
- R7: A call made while seven windows are resident pulses `ovf_trap` for one cycle, in the first cycle of a spill. The spill presents 16 words with `mem_we`=1 and `mem_word` counting from 0 to 15, and it advances only on cycles where `mem_valid` and `mem_ready` are both high. Words 0–7 are the oldest window's registers 16–23 and words 8–15 are its registers 24–31.
- R8: `stall` is high from the cycle after an overflowing call or underflowing return until the sixteenth word is accepted. It is low in the cycle after that, with the pending call or return completed.
- R9: A return made when the current window is the only resident one and the depth is nonzero pulses `unf_trap` for one cycle. The block then reads 16 words with `mem_we`=0 in the same order as R7, taking each from `mem_rdata` on an accepted cycle. After the return completes, the caller's registers read as they were before the spill.
- R10: A return at nesting depth zero pulses `ret_err` for one cycle in the next cycle and leaves every register view unchanged.
- R11: While `stall` is high, `we`, `call` and `ret` are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ra0 | input | 5 | Logical address, read port 0 |
| rd0 | output | 32 | Read data, port 0 (combinational) |
| ra1 | input | 5 | Logical address, read port 1 |
| rd1 | output | 32 | Read data, port 1 (combinational) |
| we | input | 1 | Write enable |
| wa | input | 5 | Logical write address |
| wd | input | 32 | Write data |
| call | input | 1 | Call strobe (takes priority over ret) |
| ret | input | 1 | Return strobe |
| stall | output | 1 | Spill or fill in progress |
| ovf_trap | output | 1 | One-cycle overflow trap pulse |
| unf_trap | output | 1 | One-cycle underflow trap pulse |
| ret_err | output | 1 | One-cycle pulse for a return at depth zero |
| mem_valid | output | 1 | Transfer word request |
| mem_we | output | 1 | 1 = spill (write to memory), 0 = fill |
| mem_word | output | 4 | Word index within the 16-word transfer |
| mem_wdata | output | 32 | Spill data |
| mem_rdata | input | 32 | Fill data, sampled on accepted fill cycles |
| mem_ready | input | 1 | Memory accepts or supplies the current word |

## Verification
Two functions can meet in one cycle. The first is a write and a read of the same register. The second is a write together with a call or return. The random driver aims read port 0 at the write address half the time, and it issues writes in the same cycles as call strobes, so both overlaps happen often at every depth, including around spills and fills. A behavioural model with one array per nesting depth predicts every read in every cycle: it forwards the write data on an address match and applies the write before changing depth. Any forwarding slip, or a write landing in the wrong window, shows up as a read mismatch.

// File: rtl/rwin_pkg.sv
// Package: shared types for the register window file.
// Assumes: nothing beyond the standard language.
package rwin_pkg;
    typedef enum logic [1:0] {
        XF_IDLE  = 2'd0,
        XF_SPILL = 2'd1,
        XF_FILL  = 2'd2
    } xfer_e;
endpackage

// File: rtl/rwin_map.sv
// Module: rwin_map
// Translates a logical register number into a physical storage index.
// Physical index 0..GRP-1 holds the globals. Slot w (2*GRP words) starts at
// GRP + w*2*GRP: its first half is the outgoing group, its second half the locals.
// The incoming group of window w is the outgoing half of slot w-1.
// Assumes: NWIN and GRP are powers of two, so pointer arithmetic wraps modulo NWIN.
module rwin_map #(
    parameter int GRP  = 8,
    parameter int NWIN = 8,
    parameter int GW   = $clog2(GRP),
    parameter int LW   = GW + 2,
    parameter int WPW  = $clog2(NWIN),
    parameter int PW   = $clog2(GRP + NWIN * 2 * GRP)
) (
    input  logic [LW-1:0]  lreg,
    input  logic [WPW-1:0] cwp,
    output logic [PW-1:0]  pidx
);
    localparam int SLOT = 2 * GRP;

    logic [1:0]     grp;
    logic [GW-1:0]  off;
    logic [WPW-1:0] wsel;

    // Purpose: select the window slot and the group offset for the register.
    always_comb begin
        grp  = lreg[LW-1 -: 2];
        off  = lreg[GW-1:0];
        wsel = (grp == 2'd3) ? cwp - 1'b1 : cwp;
        if (grp == 2'd0)
            pidx = PW'(off);
        else
            pidx = PW'(GRP) + PW'(wsel) * PW'(SLOT)
                 + ((grp == 2'd2) ? PW'(GRP) : '0) + PW'(off);
    end
endmodule

// File: rtl/rwin_store.sv
// Module: rwin_store
// Physical register array: one write port and three combinational read ports.
// A read whose address matches the write in the same cycle returns the write data.
// Index 0 is never written, so it always reads zero.
// Assumes: callers present indices below NPHYS.
module rwin_store #(
    parameter int DW    = 32,
    parameter int NPHYS = 136,
    parameter int PW    = $clog2(NPHYS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [PW-1:0] widx,
    input  logic [DW-1:0] wdata,
    input  logic [PW-1:0] ridx0,
    input  logic [PW-1:0] ridx1,
    input  logic [PW-1:0] ridx2,
    output logic [DW-1:0] rdata0,
    output logic [DW-1:0] rdata1,
    output logic [DW-1:0] rdata2
);
    logic [DW-1:0] mem [NPHYS];
    logic          wr_ok;

    assign wr_ok = we && (widx != '0);

    // Purpose: clear the array on reset, otherwise store accepted writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NPHYS; i++) mem[i] <= '0;
        end else if (wr_ok) begin
            mem[widx] <= wdata;
        end
    end

    // Purpose: read with same-cycle forwarding of the write data.
    always_comb begin
        rdata0 = (wr_ok && widx == ridx0) ? wdata : mem[ridx0];
        rdata1 = (wr_ok && widx == ridx1) ? wdata : mem[ridx1];
        rdata2 = (wr_ok && widx == ridx2) ? wdata : mem[ridx2];
    end
endmodule

// File: rtl/rwin_ctrl.sv
// Module: rwin_ctrl
// Holds the current and saved window pointers and the nesting depth, and runs
// the spill/fill sequencer. A transfer moves 2*GRP words: the locals of the
// target window first, then its incoming group.
// Assumes: NWIN and GRP are powers of two; the depth never exceeds 2**DEPTH_W-1.
module rwin_ctrl
    import rwin_pkg::*;
#(
    parameter int NWIN    = 8,
    parameter int GRP     = 8,
    parameter int DEPTH_W = 8,
    parameter int GW      = $clog2(GRP),
    parameter int XW      = GW + 1,
    parameter int WPW     = $clog2(NWIN),
    parameter int PW      = $clog2(GRP + NWIN * 2 * GRP)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           call,
    input  logic           ret,
    input  logic           mem_ready,
    output logic [WPW-1:0] cwp,
    output logic           stall,
    output logic           ovf_trap,
    output logic           unf_trap,
    output logic           ret_err,
    output logic           mem_valid,
    output logic           mem_we,
    output logic [XW-1:0]  mem_word,
    output logic [PW-1:0]  xfer_idx,
    output logic           fill_we
);
    localparam int          SLOT = 2 * GRP;
    localparam logic [XW-1:0] LAST = XW'(SLOT - 1);

    xfer_e              st_q;
    logic [WPW-1:0]     cwp_q, swp_q, gap, tw, tw2;
    logic [DEPTH_W-1:0] depth_q;
    logic [XW-1:0]      word_q;
    logic               ovf_q, unf_q, err_q, full, alone, is_par, acc;

    assign gap      = cwp_q - swp_q;
    assign full     = (gap == WPW'(NWIN - 2));
    assign alone    = (cwp_q == swp_q);
    assign acc      = (st_q != XF_IDLE) && mem_ready;
    assign cwp      = cwp_q;
    assign stall    = (st_q != XF_IDLE);
    assign mem_valid = (st_q != XF_IDLE);
    assign mem_we   = (st_q == XF_SPILL);
    assign mem_word = word_q;
    assign fill_we  = (st_q == XF_FILL) && mem_ready;
    assign ovf_trap = ovf_q;
    assign unf_trap = unf_q;
    assign ret_err  = err_q;

    // Purpose: physical index of the word being transferred.
    always_comb begin
        is_par   = word_q[XW-1];
        tw       = (st_q == XF_FILL) ? swp_q - 1'b1 : swp_q;
        tw2      = is_par ? tw - 1'b1 : tw;
        xfer_idx = PW'(GRP) + PW'(tw2) * PW'(SLOT)
                 + (is_par ? '0 : PW'(GRP)) + PW'(word_q[GW-1:0]);
    end

    // Purpose: pointer updates, trap pulses and transfer sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= XF_IDLE;
            cwp_q   <= '0;
            swp_q   <= '0;
            depth_q <= '0;
            word_q  <= '0;
            ovf_q   <= 1'b0;
            unf_q   <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            ovf_q <= 1'b0;
            unf_q <= 1'b0;
            err_q <= 1'b0;
            if (st_q == XF_IDLE) begin
                if (call) begin
                    if (full) begin
                        st_q   <= XF_SPILL;
                        word_q <= '0;
                        ovf_q  <= 1'b1;
                    end else begin
                        cwp_q   <= cwp_q + 1'b1;
                        depth_q <= depth_q + 1'b1;
                    end
                end else if (ret) begin
                    if (depth_q == '0) begin
                        err_q <= 1'b1;
                    end else if (alone) begin
                        st_q   <= XF_FILL;
                        word_q <= '0;
                        unf_q  <= 1'b1;
                    end else begin
                        cwp_q   <= cwp_q - 1'b1;
                        depth_q <= depth_q - 1'b1;
                    end
                end
            end else if (acc) begin
                if (word_q == LAST) begin
                    st_q <= XF_IDLE;
                    if (st_q == XF_SPILL) begin
                        swp_q   <= swp_q + 1'b1;
                        cwp_q   <= cwp_q + 1'b1;
                        depth_q <= depth_q + 1'b1;
                    end else begin
                        swp_q   <= swp_q - 1'b1;
                        cwp_q   <= cwp_q - 1'b1;
                        depth_q <= depth_q - 1'b1;
                    end
                end else begin
                    word_q <= word_q + 1'b1;
                end
            end
        end
    end

    // R7: an overflow trap coincides with the first word of a spill.
    a_r7_trap_starts_spill: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_trap |-> (mem_valid && mem_we && mem_word == '0));

    // R9: an underflow trap coincides with the first word of a fill.
    a_r9_trap_starts_fill: assert property (@(posedge clk) disable iff (!rst_n)
        unf_trap |-> (mem_valid && !mem_we && mem_word == '0));

    // R7: an accepted word that is not the last moves to the next word index.
    a_r7_word_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_ready && mem_word != LAST) |=> (mem_word == $past(mem_word) + 1'b1));

    // R11: without ready, the request and the window are held.
    a_r11_hold_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_word) && $stable(mem_we) && $stable(cwp_q)));

    // R8: the last accepted spill word completes the call.
    a_r8_spill_done: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_we && mem_ready && mem_word == LAST) |=> (!stall && cwp_q == $past(cwp_q) + 1'b1));

    // R10: an error pulse comes with no pointer movement.
    a_r10_no_move: assert property (@(posedge clk) disable iff (!rst_n)
        ret_err |-> ($stable(cwp_q) && $stable(depth_q) && !stall));
endmodule

// File: rtl/rwin_regfile.sv
// Module: rwin_regfile (top)
// Windowed register file: two read ports, one write port, call/return window
// switching, and a valid/ready word port for spilling and filling windows.
// Assumes: call/ret are one-cycle strobes and the core waits while stall is high.
module rwin_regfile #(
    parameter int DW      = 32,
    parameter int NWIN    = 8,
    parameter int GRP     = 8,
    parameter int DEPTH_W = 8,
    parameter int GW      = $clog2(GRP),
    parameter int LW      = GW + 2,
    parameter int XW      = GW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [LW-1:0] ra0,
    output logic [DW-1:0] rd0,
    input  logic [LW-1:0] ra1,
    output logic [DW-1:0] rd1,
    input  logic          we,
    input  logic [LW-1:0] wa,
    input  logic [DW-1:0] wd,
    input  logic          call,
    input  logic          ret,
    output logic          stall,
    output logic          ovf_trap,
    output logic          unf_trap,
    output logic          ret_err,
    output logic          mem_valid,
    output logic          mem_we,
    output logic [XW-1:0] mem_word,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_ready
);
    localparam int NPHYS = GRP + NWIN * 2 * GRP;
    localparam int PW    = $clog2(NPHYS);
    localparam int WPW   = $clog2(NWIN);
    localparam int NPORT = 3;

    logic [WPW-1:0] cwp;
    logic [LW-1:0]  lreg [NPORT];
    logic [PW-1:0]  pidx [NPORT];
    logic [PW-1:0]  xfer_idx, s_widx;
    logic [DW-1:0]  s_wdata;
    logic           fill_we, s_we;

    assign lreg[0] = ra0;
    assign lreg[1] = ra1;
    assign lreg[2] = wa;

    // Address translation for both read ports and the write port.
    for (genvar i = 0; i < NPORT; i++) begin : g_map
        rwin_map #(.GRP(GRP), .NWIN(NWIN)) u_map (
            .lreg (lreg[i]),
            .cwp  (cwp),
            .pidx (pidx[i])
        );
    end

    rwin_ctrl #(.NWIN(NWIN), .GRP(GRP), .DEPTH_W(DEPTH_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .call      (call),
        .ret       (ret),
        .mem_ready (mem_ready),
        .cwp       (cwp),
        .stall     (stall),
        .ovf_trap  (ovf_trap),
        .unf_trap  (unf_trap),
        .ret_err   (ret_err),
        .mem_valid (mem_valid),
        .mem_we    (mem_we),
        .mem_word  (mem_word),
        .xfer_idx  (xfer_idx),
        .fill_we   (fill_we)
    );

    // Purpose: the fill sequencer owns the write port during a transfer.
    always_comb begin
        s_we    = fill_we || (we && !stall);
        s_widx  = fill_we ? xfer_idx : pidx[2];
        s_wdata = fill_we ? mem_rdata : wd;
    end

    rwin_store #(.DW(DW), .NPHYS(NPHYS)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (s_we),
        .widx   (s_widx),
        .wdata  (s_wdata),
        .ridx0  (pidx[0]),
        .ridx1  (pidx[1]),
        .ridx2  (xfer_idx),
        .rdata0 (rd0),
        .rdata1 (rd1),
        .rdata2 (mem_wdata)
    );
endmodule

// File: tb/sim_rwin_regfile.sv
// Bench: behavioural model with one register array per nesting depth, compared every cycle.
`timescale 1ns/1ps
module sim_rwin_regfile;
    localparam int NWIN = 8;
    localparam int MAXD = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  ra0 = '0, ra1 = '0, wa = '0;
    logic [31:0] rd0, rd1, wd = '0, mem_wdata, mem_rdata = '0;
    logic        we = 1'b0, call = 1'b0, ret = 1'b0, mem_ready = 1'b0;
    logic        stall, ovf_trap, unf_trap, ret_err, mem_valid, mem_we;
    logic [3:0]  mem_word;

    always #4 clk = ~clk;

    rwin_regfile u0 (
        .clk(clk), .rst_n(rst_n), .ra0(ra0), .rd0(rd0), .ra1(ra1), .rd1(rd1),
        .we(we), .wa(wa), .wd(wd), .call(call), .ret(ret), .stall(stall),
        .ovf_trap(ovf_trap), .unf_trap(unf_trap), .ret_err(ret_err),
        .mem_valid(mem_valid), .mem_we(mem_we), .mem_word(mem_word),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready)
    );

    int nchecks = 0, nerr = 0;
    int depth, lo, mode, wcnt;
    bit e_ovf, e_unf, e_err;
    logic [31:0] glob [8];
    logic [31:0] loc  [MAXD][8];
    bit          loc_v [MAXD][8];
    logic [31:0] outg [MAXD+1][8];
    bit          outg_v [MAXD+1][8];
    logic [31:0] mstore [MAXD][16];

    function automatic void chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        nchecks++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endfunction

    function automatic logic [31:0] mread(int r, int d);
        if (r == 0) return '0;
        if (r < 8) return glob[r];
        if (r < 16) return outg[d+1][r-8];
        if (r < 24) return loc[d][r-16];
        return outg[d][r-24];
    endfunction

    function automatic bit mvalid(int r, int d);
        if (r < 8) return 1'b1;
        if (r < 16) return outg_v[d+1][r-8];
        if (r < 24) return loc_v[d][r-16];
        return outg_v[d][r-24];
    endfunction

    function automatic void mwrite(int r, int d, logic [31:0] v);
        if (r == 0) return;
        if (r < 8) glob[r] = v;
        else if (r < 16) begin outg[d+1][r-8] = v; outg_v[d+1][r-8] = 1'b1; end
        else if (r < 24) begin loc[d][r-16] = v; loc_v[d][r-16] = 1'b1; end
        else begin outg[d][r-24] = v; outg_v[d][r-24] = 1'b1; end
    endfunction

    // A fresh callee window has undefined locals and outgoing registers.
    function automatic void newwin(int d);
        for (int k = 0; k < 8; k++) begin
            loc_v[d][k] = 1'b0;
            outg_v[d+1][k] = 1'b0;
        end
    endfunction

    function automatic string rtag(int r, bit w, int wa_i);
        if (r == 0) return "R2";
        if (w && mode == 0 && wa_i == r) return "R5";
        if (r < 8) return "R3";
        return "R4";
    endfunction

    function automatic void rcheck(int r, logic [31:0] act, bit w, int wa_i, logic [31:0] wd_i, string port);
        logic [31:0] e;
        bit v;
        if (mode == 0 && w && wa_i == r && r != 0) begin e = wd_i; v = 1'b1; end
        else begin e = mread(r, depth); v = mvalid(r, depth); end
        if (v) chk(act === e, rtag(r, w, wa_i), port, act, e);
    endfunction

    // One clock cycle: drive at the falling edge, check, then advance the model at the rising edge.
    task automatic op(input bit c, input bit r, input bit w, input int wa_i, input logic [31:0] wd_i,
                      input int ra0_i, input int ra1_i);
        bit acc;
        @(negedge clk);
        call = c; ret = r; we = w; wa = 5'(wa_i); wd = wd_i;
        ra0 = 5'(ra0_i); ra1 = 5'(ra1_i);
        mem_ready = (($urandom % 10) < 7);
        mem_rdata = (mode == 2) ? mstore[lo-1][mem_word] : 32'h0;
        #1;
        chk(stall === (mode != 0), "R8", "stall", 32'(stall), 32'(mode != 0));
        chk(mem_valid === (mode != 0), "R8", "mem_valid", 32'(mem_valid), 32'(mode != 0));
        chk(ovf_trap === e_ovf, "R7", "ovf_trap", 32'(ovf_trap), 32'(e_ovf));
        chk(unf_trap === e_unf, "R9", "unf_trap", 32'(unf_trap), 32'(e_unf));
        chk(ret_err === e_err, "R10", "ret_err", 32'(ret_err), 32'(e_err));
        if (mode != 0) begin
            chk(mem_we === (mode == 1), (mode == 1) ? "R7" : "R9", "mem_we", 32'(mem_we), 32'(mode == 1));
            chk(mem_word === 4'(wcnt), (mode == 1) ? "R7" : "R9", "mem_word", 32'(mem_word), 32'(wcnt));
        end
        rcheck(ra0_i, rd0, w, wa_i, wd_i, "rd0");
        rcheck(ra1_i, rd1, w, wa_i, wd_i, "rd1");
        acc = mem_valid && mem_ready;
        if (mode == 1 && acc) begin
            mstore[lo][wcnt] = mem_wdata;
            if (wcnt < 8 && loc_v[lo][wcnt])
                chk(mem_wdata === loc[lo][wcnt], "R7", "spill local word", mem_wdata, loc[lo][wcnt]);
            if (wcnt >= 8 && outg_v[lo][wcnt-8])
                chk(mem_wdata === outg[lo][wcnt-8], "R7", "spill param word", mem_wdata, outg[lo][wcnt-8]);
        end
        @(posedge clk);
        e_ovf = 1'b0; e_unf = 1'b0; e_err = 1'b0;
        if (mode == 0) begin
            if (w) mwrite(wa_i, depth, wd_i);
            if (c) begin
                if (depth - lo == NWIN - 2) begin mode = 1; wcnt = 0; e_ovf = 1'b1; end
                else begin newwin(depth + 1); depth++; end
            end else if (r) begin
                if (depth == 0) e_err = 1'b1;
                else if (depth == lo) begin mode = 2; wcnt = 0; e_unf = 1'b1; end
                else depth--;
            end
        end else if (acc) begin
            wcnt++;
            if (wcnt == 16) begin
                if (mode == 1) begin lo++; newwin(depth + 1); depth++; end
                else begin lo--; depth--; end
                mode = 0;
            end
        end
    endtask

    // Idle cycles until the model reports no transfer; optionally drive inputs that must be ignored (R11).
    task automatic wait_idle(input bit noisy);
        while (mode != 0) op(noisy, noisy, noisy, 3, 32'hBAD0_0BAD, 3, 20);
    endtask

    // Read one register with the block idle and compare against a stated value.
    task automatic peek(input int r, input logic [31:0] e, input string req);
        @(negedge clk);
        call = 1'b0; ret = 1'b0; we = 1'b0; mem_ready = 1'b0; ra0 = 5'(r);
        #1;
        chk(rd0 === e, req, "directed read", rd0, e);
    endtask

    task automatic summary;
        $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nerr++;
        $display("FAIL R8 watchdog expired: actual=%0d expected=%0d", 200000, 0);
        summary();
        $finish;
    end

    initial begin
        depth = 0; lo = 0; mode = 0; wcnt = 0;
        e_ovf = 1'b0; e_unf = 1'b0; e_err = 1'b0;
        for (int i = 0; i < 8; i++) glob[i] = '0;
        for (int d = 0; d < MAXD; d++)
            for (int k = 0; k < 8; k++) begin
                loc[d][k] = '0; loc_v[d][k] = 1'b0;
                outg[d][k] = '0; outg_v[d][k] = 1'b0;
            end
        for (int k = 0; k < 8; k++) begin
            outg[MAXD][k] = '0; outg_v[MAXD][k] = 1'b0;
            loc_v[0][k] = 1'b1; outg_v[0][k] = 1'b1; outg_v[1][k] = 1'b1;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        ra0 = 5'd20; ra1 = 5'd27;
        #1;
        chk(rd0 === 32'h0, "R1", "local after reset", rd0, 32'h0);
        chk(rd1 === 32'h0, "R1", "param after reset", rd1, 32'h0);
        chk(stall === 1'b0, "R1", "stall after reset", 32'(stall), 32'h0);
        chk(mem_valid === 1'b0, "R1", "mem_valid after reset", 32'(mem_valid), 32'h0);
        chk({ovf_trap, unf_trap, ret_err} === 3'b000, "R1", "pulses after reset",
            32'({ovf_trap, unf_trap, ret_err}), 32'h0);

        // R10: return at depth zero
        op(0, 1, 0, 0, 0, 16, 24);
        op(0, 0, 0, 0, 0, 16, 24);
        // R2: writes to register 0 vanish
        op(0, 0, 1, 0, 32'hFFFF_FFFF, 0, 0);
        peek(0, 32'h0, "R2");
        // R3: a global seen from a deeper window
        op(0, 0, 1, 3, 32'h0000_0033, 3, 3);
        // R4: outgoing becomes incoming across a call, restored on return
        op(0, 0, 1, 9, 32'hA5A5_0004, 9, 9);
        op(1, 0, 0, 0, 0, 0, 0);
        peek(25, 32'hA5A5_0004, "R4");
        peek(3, 32'h0000_0033, "R3");
        op(0, 1, 0, 0, 0, 0, 0);
        peek(9, 32'hA5A5_0004, "R4");
        // R6: write in the same cycle as a call lands in the caller
        op(1, 0, 1, 17, 32'hC0DE_0006, 17, 9);
        op(0, 0, 1, 17, 32'h1111_2222, 17, 17);
        op(0, 1, 0, 0, 0, 0, 0);
        peek(17, 32'hC0DE_0006, "R6");
        // R7/R8/R11: deep calls force a spill; inputs during the stall are ignored
        for (int i = 0; i < 8; i++) begin
            op(1, 0, 1, 16, 32'h5000_0000 + 32'(i), 16, 24);
            wait_idle(1'b1);
        end
        peek(3, 32'h0000_0033, "R11");
        // R9: returning back down forces a fill
        for (int i = 0; i < 8; i++) begin
            op(0, 1, 0, 0, 0, 16, 24);
            wait_idle(1'b0);
        end
        peek(17, 32'hC0DE_0006, "R9");

        // Random phases: deepen, unwind, mix, drain to zero
        for (int i = 0; i < 8000; i++) begin
            int ph, pc, pr, wa_i, ra0_i;
            bit c, r;
            ph = (i / 500) % 4;
            pc = (ph == 0) ? 45 : (ph == 1) ? 10 : (ph == 2) ? 25 : 5;
            pr = (ph == 0) ? 10 : (ph == 1) ? 45 : (ph == 2) ? 25 : 55;
            c = (($urandom % 100) < pc) && (depth < MAXD - 8);
            r = !c && (($urandom % 100) < pr);
            wa_i = $urandom % 32;
            ra0_i = (($urandom % 2) == 0) ? wa_i : int'($urandom % 32);
            op(c, r, (($urandom % 10) < 6), wa_i, $urandom, ra0_i, $urandom % 32);
        end
        wait_idle(1'b0);
        summary();
        $finish;
    end
endmodule